// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the processor-facing register file of a 16550-compatible serial port. A host reaches it through a simple strobed bus with a 3-bit offset and 8-bit data. The meaning of several offsets depends on the value held in the line-control register. When bit 7 of that register is set, the two lowest offsets reach the baud divisor. When the register holds a fixed key value (0xBF by default), offset 2 reaches an enhanced flow-control register and the scratch location becomes invisible.

The serializer, the baud generator and the FIFO storage are outside this block. It receives plain status from them: receive data available, the byte at the head of the receive queue, a receive overrun pulse, transmitter room and transmitter empty. It returns pop and push strobes, FIFO flush pulses, the divisor, the FIFO mode and the flow-control settings. It also builds the interrupt identification code and the interrupt request from the enable register and those status inputs.

Top module: `uart_regbank`

## Requirements
- R1: After reset the line-control, interrupt-enable, modem-control, divisor, enhanced and FIFO settings are all zero; the interrupt identification (offset 2) reads 0x01, the modem status reads 0x00 and irq is low.
- R2: With line-control bit 7 clear, offset 1 reads back the low 4 bits written (upper bits 0), offset 3 reads back all 8 bits, and offset 7 keeps and returns any byte written.
- R3: With line-control bit 7 clear, a read of offset 0 returns rx_data and pulses rx_pop in that cycle only when rx_avail is 1; a write of offset 0 presents the byte on tx_data with tx_push high for that cycle.
- R4: With line-control bit 7 set, offsets 0 and 1 write and read the low and high divisor bytes (divisor = {high, low}); no rx_pop or tx_push occurs and the interrupt-enable value is untouched.
- R5: With line-control equal to the key value, offset 2 writes and reads the enhanced register, offset 7 reads 0x00 and ignores writes, and the earlier scratch byte returns once line control changes.
- R6: A write to offset 2 outside the key bank sets the FIFO enable from data bit 0 and pulses rx_flush for data bit 1 and tx_flush for data bit 2; identification bits 7:6 read 11 while FIFOs are enabled and 00 otherwise.
- R7: FIFO-control bit 5 (large FIFO mode) is stored only when line-control bit 7 is set at the write; identification bit 5 and fifo_big read 1 only while FIFOs are enabled and large mode is stored.
- R8: Line status reads {0, tx_empty, tx_room, 0, 0, 0, overrun, rx_avail}; the overrun bit is set by an rx_overrun pulse and cleared by a read of offset 5.
- R9: Modem control keeps bits 5:0 (bits 7:6 read 0); dtr_o is bit 0, rts_o is bit 1, auto_cts is enhanced bit 7 or modem bit 5, auto_rts is enhanced bit 6 or (modem bit 5 and modem bit 1).
- R10: Modem status bits 7:4 show modem_in[3:0] one clock late; bits 3:0 each latch a change of the matching line and clear on a read of offset 6.
- R11: Identification bits 3:0 follow the priority 0x6 (overrun, enable bit 2) over 0x4 (rx_avail, enable bit 0) over 0x2 (tx_room, enable bit 1) over 0x0 (any modem change, enable bit 3) over 0x1 (none); irq is high exactly when the code is not 0x1.
- R12: Writes to offsets 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| rx_avail | input | 1 | Receive queue holds at least one byte |
| rx_data | input | 8 | Byte at the head of the receive queue |
| rx_overrun | input | 1 | Receive overrun pulse |
| rx_pop | output | 1 | Remove the head byte of the receive queue |
| tx_room | input | 1 | Transmit queue can take a byte |
| tx_empty | input | 1 | Transmitter fully idle |
| tx_push | output | 1 | Push tx_data into the transmit queue |
| tx_data | output | 8 | Byte to transmit |
| rx_flush | output | 1 | Receive queue clear pulse |
| tx_flush | output | 1 | Transmit queue clear pulse |
| modem_in | input | 4 | Modem input lines |
| divisor | output | 16 | Baud divisor |
| fifo_on | output | 1 | FIFO mode enabled |
| fifo_big | output | 1 | Large FIFO mode active |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| auto_cts | output | 1 | Automatic CTS flow control enable |
| auto_rts | output | 1 | Automatic RTS flow control enable |
| irq | output | 1 | Interrupt request |

## Verification
The same offsets are written and read under three line-control values: plain, divisor access and the key value. This shows that each bank reaches its own storage and leaves the others intact. The FIFO-control write is tried with the divisor bit both set and clear, which tells the gated large-mode bit apart from the free enable bit. Interrupt sources are raised one on top of another and then removed one by one, so that each step of the priority order shows up. Receive reads are tried with data present and absent, which separates a real pop from a plain read.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
   localparam int unsigned OFS_W = 3;

   localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
   localparam logic [OFS_W-1:0] OFS_IEN   = 3'd1;
   localparam logic [OFS_W-1:0] OFS_IDF   = 3'd2;
   localparam logic [OFS_W-1:0] OFS_LCTL  = 3'd3;
   localparam logic [OFS_W-1:0] OFS_MCTL  = 3'd4;
   localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;
   localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;
   localparam logic [OFS_W-1:0] OFS_SCR   = 3'd7;

   localparam int unsigned LCR_BANK_BIT = 7;
   localparam int unsigned FCR_EN_BIT   = 0;
   localparam int unsigned FCR_RXC_BIT  = 1;
   localparam int unsigned FCR_TXC_BIT  = 2;
   localparam int unsigned FCR_BIG_BIT  = 5;
   localparam int unsigned MCR_DTR_BIT  = 0;
   localparam int unsigned MCR_RTS_BIT  = 1;
   localparam int unsigned MCR_AFC_BIT  = 5;
   localparam int unsigned EFR_RTS_BIT  = 6;
   localparam int unsigned EFR_CTS_BIT  = 7;

   typedef enum logic [3:0] {
      ID_MODEM = 4'h0,
      ID_NONE  = 4'h1,
      ID_TXE   = 4'h2,
      ID_RXD   = 4'h4,
      ID_LINE  = 4'h6
   } int_id_e;

   typedef struct packed {
      logic thr_wr;
      logic dll_wr;
      logic dlm_wr;
      logic ier_wr;
      logic fcr_wr;
      logic efr_wr;
      logic lcr_wr;
      logic mcr_wr;
      logic scr_wr;
      logic rbr_rd;
      logic lsr_rd;
      logic msr_rd;
   } reg_strobe_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
   import uart_rb_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          ENH_EN  = 1'b1,
   parameter logic [7:0]  ENH_KEY = 8'hBF
) (
   input  logic [DATA_W-1:0] lcr,
   input  logic              wr,
   input  logic              rd,
   input  logic [OFS_W-1:0]  addr,
   output reg_strobe_t       stb,
   output logic              dlab,
   output logic              enh_bank
);
   assign dlab = lcr[LCR_BANK_BIT];

   generate
      if (ENH_EN) begin : g_enh
         assign enh_bank = (lcr == ENH_KEY);
      end else begin : g_noenh
         assign enh_bank = 1'b0;
      end
   endgenerate

   always_comb begin
      stb = '0;
      case (addr)
         OFS_DATA: begin
            stb.dll_wr = wr & dlab;
            stb.thr_wr = wr & ~dlab;
            stb.rbr_rd = rd & ~dlab;
         end
         OFS_IEN: begin
            stb.dlm_wr = wr & dlab;
            stb.ier_wr = wr & ~dlab;
         end
         OFS_IDF: begin
            stb.efr_wr = wr & enh_bank;
            stb.fcr_wr = wr & ~enh_bank;
         end
         OFS_LCTL:  stb.lcr_wr = wr;
         OFS_MCTL:  stb.mcr_wr = wr;
         OFS_LSTAT: stb.lsr_rd = rd;
         OFS_MSTAT: stb.msr_rd = rd;
         OFS_SCR:   stb.scr_wr = wr & ~enh_bank;
         default: ;
      endcase
   end
endmodule

// File: rtl/uart_rb_ctrl.sv
module uart_rb_ctrl
   import uart_rb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IER_W  = 4,
   parameter int unsigned MCR_W  = 6,
   parameter bit          BIG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  reg_strobe_t       stb,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dlab,
   output logic [DATA_W-1:0] lcr_q,
   output logic [IER_W-1:0]  ier_q,
   output logic [MCR_W-1:0]  mcr_q,
   output logic [DATA_W-1:0] dll_q,
   output logic [DATA_W-1:0] dlm_q,
   output logic [DATA_W-1:0] efr_q,
   output logic [DATA_W-1:0] scr_q,
   output logic              fen_q,
   output logic              big_q,
   output logic              rx_flush,
   output logic              tx_flush
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q <= '0;
         ier_q <= '0;
         mcr_q <= '0;
         dll_q <= '0;
         dlm_q <= '0;
         efr_q <= '0;
         fen_q <= 1'b0;
      end else begin
         if (stb.lcr_wr) lcr_q <= wdata;
         if (stb.ier_wr) ier_q <= wdata[IER_W-1:0];
         if (stb.mcr_wr) mcr_q <= wdata[MCR_W-1:0];
         if (stb.dll_wr) dll_q <= wdata;
         if (stb.dlm_wr) dlm_q <= wdata;
         if (stb.efr_wr) efr_q <= wdata;
         if (stb.fcr_wr) fen_q <= wdata[FCR_EN_BIT];
      end
   end

   // scratch byte has no reset value
   always_ff @(posedge clk) begin
      if (stb.scr_wr) scr_q <= wdata;
   end

   generate
      if (BIG_EN) begin : g_big
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 big_q <= 1'b0;
            else if (stb.fcr_wr && dlab) big_q <= wdata[FCR_BIG_BIT];
         end
      end else begin : g_nobig
         assign big_q = 1'b0;
      end
   endgenerate

   assign rx_flush = stb.fcr_wr & wdata[FCR_RXC_BIT];
   assign tx_flush = stb.fcr_wr & wdata[FCR_TXC_BIT];
endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status
   import uart_rb_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MODEM_N = 4,
   parameter int unsigned IER_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  reg_strobe_t        stb,
   input  logic               rx_avail,
   input  logic               rx_overrun,
   input  logic               tx_room,
   input  logic               tx_empty,
   input  logic [MODEM_N-1:0] modem_in,
   input  logic [IER_W-1:0]   ier,
   input  logic               fen,
   input  logic               big,
   output logic [DATA_W-1:0]  lsr,
   output logic [DATA_W-1:0]  msr,
   output logic [DATA_W-1:0]  iir,
   output logic               irq
);
   logic               ovr_q;
   logic [MODEM_N-1:0] mod_q;
   logic [MODEM_N-1:0] dlt_q;
   int_id_e            id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         mod_q <= '0;
         dlt_q <= '0;
      end else begin
         if (rx_overrun)      ovr_q <= 1'b1;
         else if (stb.lsr_rd) ovr_q <= 1'b0;
         mod_q <= modem_in;
         dlt_q <= (stb.msr_rd ? '0 : dlt_q) | (modem_in ^ mod_q);
      end
   end

   always_comb begin
      lsr    = '0;
      lsr[0] = rx_avail;
      lsr[1] = ovr_q;
      lsr[5] = tx_room;
      lsr[6] = tx_empty;
   end

   assign msr = {mod_q, dlt_q};

   always_comb begin
      if (ier[2] && ovr_q)          id = ID_LINE;
      else if (ier[0] && rx_avail)  id = ID_RXD;
      else if (ier[1] && tx_room)   id = ID_TXE;
      else if (ier[3] && |dlt_q)    id = ID_MODEM;
      else                          id = ID_NONE;
   end

   assign iir = {fen, fen, fen & big, 1'b0, id};
   assign irq = (id != ID_NONE);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MODEM_N = 4,
   parameter bit          ENH_EN  = 1'b1,
   parameter bit          BIG_EN  = 1'b1,
   parameter logic [7:0]  ENH_KEY = 8'hBF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [2:0]          bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                rx_avail,
   input  logic [DATA_W-1:0]   rx_data,
   input  logic                rx_overrun,
   output logic                rx_pop,
   input  logic                tx_room,
   input  logic                tx_empty,
   output logic                tx_push,
   output logic [DATA_W-1:0]   tx_data,
   output logic                rx_flush,
   output logic                tx_flush,
   input  logic [MODEM_N-1:0]  modem_in,
   output logic [2*DATA_W-1:0] divisor,
   output logic                fifo_on,
   output logic                fifo_big,
   output logic                dtr_o,
   output logic                rts_o,
   output logic                auto_cts,
   output logic                auto_rts,
   output logic                irq
);
   localparam int unsigned IER_W = MODEM_N;
   localparam int unsigned MCR_W = 6;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("uart_regbank: DATA_W must be 8");
      end
      if (2 * MODEM_N != DATA_W) begin : g_bad_modem
         $error("uart_regbank: MODEM_N must fill half a register");
      end
   endgenerate

   reg_strobe_t       stb;
   logic              dlab;
   logic              enh_bank;
   logic [DATA_W-1:0] lcr_q, dll_q, dlm_q, efr_q, scr_q;
   logic [IER_W-1:0]  ier_q;
   logic [MCR_W-1:0]  mcr_q;
   logic              fen_q, big_q;
   logic [DATA_W-1:0] lsr_w, msr_w, iir_w;

   uart_rb_decode #(
      .DATA_W (DATA_W),
      .ENH_EN (ENH_EN),
      .ENH_KEY(ENH_KEY)
   ) u_dec (
      .lcr     (lcr_q),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .addr    (bus_addr),
      .stb     (stb),
      .dlab    (dlab),
      .enh_bank(enh_bank)
   );

   uart_rb_ctrl #(
      .DATA_W(DATA_W),
      .IER_W (IER_W),
      .MCR_W (MCR_W),
      .BIG_EN(BIG_EN)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (stb),
      .wdata   (bus_wdata),
      .dlab    (dlab),
      .lcr_q   (lcr_q),
      .ier_q   (ier_q),
      .mcr_q   (mcr_q),
      .dll_q   (dll_q),
      .dlm_q   (dlm_q),
      .efr_q   (efr_q),
      .scr_q   (scr_q),
      .fen_q   (fen_q),
      .big_q   (big_q),
      .rx_flush(rx_flush),
      .tx_flush(tx_flush)
   );

   uart_rb_status #(
      .DATA_W (DATA_W),
      .MODEM_N(MODEM_N),
      .IER_W  (IER_W)
   ) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (stb),
      .rx_avail  (rx_avail),
      .rx_overrun(rx_overrun),
      .tx_room   (tx_room),
      .tx_empty  (tx_empty),
      .modem_in  (modem_in),
      .ier       (ier_q),
      .fen       (fen_q),
      .big       (big_q),
      .lsr       (lsr_w),
      .msr       (msr_w),
      .iir       (iir_w),
      .irq       (irq)
   );

   always_comb begin
      case (bus_addr)
         OFS_DATA:  bus_rdata = dlab ? dll_q : rx_data;
         OFS_IEN:   bus_rdata = dlab ? dlm_q : {{(DATA_W-IER_W){1'b0}}, ier_q};
         OFS_IDF:   bus_rdata = enh_bank ? efr_q : iir_w;
         OFS_LCTL:  bus_rdata = lcr_q;
         OFS_MCTL:  bus_rdata = {{(DATA_W-MCR_W){1'b0}}, mcr_q};
         OFS_LSTAT: bus_rdata = lsr_w;
         OFS_MSTAT: bus_rdata = msr_w;
         default:   bus_rdata = enh_bank ? '0 : scr_q;
      endcase
   end

   assign rx_pop   = stb.rbr_rd & rx_avail;
   assign tx_push  = stb.thr_wr;
   assign tx_data  = bus_wdata;
   assign divisor  = {dlm_q, dll_q};
   assign fifo_on  = fen_q;
   assign fifo_big = fen_q & big_q;
   assign dtr_o    = mcr_q[MCR_DTR_BIT];
   assign rts_o    = mcr_q[MCR_RTS_BIT];
   assign auto_cts = efr_q[EFR_CTS_BIT] | mcr_q[MCR_AFC_BIT];
   assign auto_rts = efr_q[EFR_RTS_BIT] | (mcr_q[MCR_AFC_BIT] & mcr_q[MCR_RTS_BIT]);
endmodule

// File: rtl/uart_rb_chk.sv
module uart_rb_chk #(
   parameter bit         ENH_EN  = 1'b1,
   parameter logic [7:0] ENH_KEY = 8'hBF
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_rd,
   input logic [2:0] bus_addr,
   input logic [7:0] bus_rdata,
   input logic       rx_avail,
   input logic       rx_overrun,
   input logic       rx_pop,
   input logic       irq,
   input logic       fifo_on,
   input logic [7:0] lcr_q,
   input logic [3:0] ier_q,
   input logic [7:0] iir_w,
   input logic [7:0] lsr_w,
   input logic       big_q
);
   assert_pop_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> (rx_avail && bus_rd && bus_addr == 3'd0 && !lcr_q[7]));

   assert_fifo_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iir_w[7:6] == {fifo_on, fifo_on});

   assert_big_needs_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(big_q) |-> $past(lcr_q[7]));

   assert_scr_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ENH_EN && bus_rd && bus_addr == 3'd7 && lcr_q == ENH_KEY) |-> bus_rdata == 8'h00);

   assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd5 && !rx_overrun) |=> !lsr_w[1]);

   assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q == 4'd0) |-> !irq);
endmodule

bind uart_regbank uart_rb_chk #(
   .ENH_EN (ENH_EN),
   .ENH_KEY(ENH_KEY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .rx_avail  (rx_avail),
   .rx_overrun(rx_overrun),
   .rx_pop    (rx_pop),
   .irq       (irq),
   .fifo_on   (fifo_on),
   .lcr_q     (lcr_q),
   .ier_q     (ier_q),
   .iir_w     (iir_w),
   .lsr_w     (lsr_w),
   .big_q     (big_q)
);

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        rx_avail = 1'b0, rx_overrun = 1'b0, tx_room = 1'b1, tx_empty = 1'b1;
   logic [7:0]  rx_data = '0;
   logic        rx_pop, tx_push, rx_flush, tx_flush;
   logic [7:0]  tx_data;
   logic [3:0]  modem_in = '0;
   logic [15:0] divisor;
   logic        fifo_on, fifo_big, dtr_o, rts_o, auto_cts, auto_rts, irq;

   // behavioural reference state
   logic [7:0] m_lcr = 0, m_ier = 0, m_mcr = 0, m_dll = 0, m_dlm = 0, m_efr = 0, m_scr = 0;
   logic       m_fen = 0, m_big = 0, m_ovr = 0;
   logic [3:0] m_mod = 0, m_dlt = 0;
   int n_chk = 0, n_err = 0;
   bit done = 0, run = 0;

   always #2.5 clk = ~clk;

   uart_regbank u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_avail(rx_avail), .rx_data(rx_data),
      .rx_overrun(rx_overrun), .rx_pop(rx_pop), .tx_room(tx_room), .tx_empty(tx_empty),
      .tx_push(tx_push), .tx_data(tx_data), .rx_flush(rx_flush), .tx_flush(tx_flush),
      .modem_in(modem_in), .divisor(divisor), .fifo_on(fifo_on), .fifo_big(fifo_big),
      .dtr_o(dtr_o), .rts_o(rts_o), .auto_cts(auto_cts), .auto_rts(auto_rts), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_iir();
      logic [3:0] id;
      if (m_ier[2] && m_ovr)          id = 4'h6;
      else if (m_ier[0] && rx_avail)  id = 4'h4;
      else if (m_ier[1] && tx_room)   id = 4'h2;
      else if (m_ier[3] && m_dlt != 0) id = 4'h0;
      else                            id = 4'h1;
      return {m_fen, m_fen, m_fen & m_big, 1'b0, id};
   endfunction

   function automatic logic [7:0] exp_lsr();
      return {1'b0, tx_empty, tx_room, 3'b000, m_ovr, rx_avail};
   endfunction

   // every-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && run) begin
         chk("R11 irq", irq, exp_iir() != 8'h01 && exp_iir()[3:0] != 4'h1);
         chk("R4 divisor", divisor, {m_dlm, m_dll});
         chk("R6 fifo_on", fifo_on, m_fen);
         chk("R7 fifo_big", fifo_big, m_fen & m_big);
         chk("R9 dtr", dtr_o, m_mcr[0]);
         chk("R9 rts", rts_o, m_mcr[1]);
         chk("R9 auto_cts", auto_cts, m_efr[7] | m_mcr[5]);
         chk("R9 auto_rts", auto_rts, m_efr[6] | (m_mcr[5] & m_mcr[1]));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
      @(posedge clk); #1;
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      #1;
      chk({tag, " R3 tx_push"}, tx_push, (a == 3'd0) && !m_lcr[7]);
      if (a == 3'd0 && !m_lcr[7]) chk({tag, " R3 tx_data"}, tx_data, d);
      chk({tag, " R6 rx_flush"}, rx_flush, (a == 3'd2) && (m_lcr != 8'hBF) && d[1]);
      chk({tag, " R6 tx_flush"}, tx_flush, (a == 3'd2) && (m_lcr != 8'hBF) && d[2]);
      @(posedge clk);
      case (a)
         3'd0: if (m_lcr[7]) m_dll = d;
         3'd1: if (m_lcr[7]) m_dlm = d; else m_ier = {4'h0, d[3:0]};
         3'd2: if (m_lcr == 8'hBF) m_efr = d;
               else begin
                  m_fen = d[0];
                  if (m_lcr[7]) m_big = d[5];
               end
         3'd3: m_lcr = d;
         3'd4: m_mcr = {2'b00, d[5:0]};
         3'd7: if (m_lcr != 8'hBF) m_scr = d;
         default: ;
      endcase
      #1 bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input logic exp_pop, input string tag);
      @(posedge clk); #1;
      bus_rd = 1; bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
      chk({tag, " R3 rx_pop"}, rx_pop, exp_pop);
      @(posedge clk);
      if (a == 3'd5) m_ovr = 0;
      if (a == 3'd6) m_dlt = 0;
      #1 bus_rd = 0;
   endtask

   task automatic pulse_ovr();
      @(posedge clk); #1 rx_overrun = 1;
      @(posedge clk); m_ovr = 1;
      #1 rx_overrun = 0;
   endtask

   task automatic set_modem(input logic [3:0] v);
      @(posedge clk); #1 modem_in = v;
      @(posedge clk); m_dlt = m_dlt | (v ^ m_mod); m_mod = v;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1; run = 1;
      // R1 reset values
      rd(3'd2, 8'h01, 0, "R1 iir reset");
      rd(3'd3, 8'h00, 0, "R1 lcr reset");
      rd(3'd1, 8'h00, 0, "R1 ier reset");
      rd(3'd4, 8'h00, 0, "R1 mcr reset");
      rd(3'd6, 8'h00, 0, "R1 msr reset");
      rd(3'd5, exp_lsr(), 0, "R8 lsr idle");
      // R2 plain bank
      wr(3'd1, 8'hF5, "R2");
      rd(3'd1, 8'h05, 0, "R2 ier low bits");
      wr(3'd3, 8'h03, "R2");
      rd(3'd3, 8'h03, 0, "R2 lcr");
      wr(3'd7, 8'hA5, "R2");
      rd(3'd7, 8'hA5, 0, "R2 scratch");
      // R9 modem control
      wr(3'd4, 8'hFF, "R9");
      rd(3'd4, 8'h3F, 0, "R9 mcr");
      chk("R9 auto_rts on", auto_rts, 1);
      wr(3'd4, 8'h20, "R9");
      chk("R9 auto_rts needs rts", auto_rts, 0);
      chk("R9 auto_cts afc", auto_cts, 1);
      wr(3'd4, 8'h00, "R9");
      // R3 receive / transmit
      rx_data = 8'h3C; rx_avail = 1;
      rd(3'd0, 8'h3C, 1, "R3 rx byte");
      rx_avail = 0;
      rd(3'd0, 8'h3C, 0, "R3 rx empty no pop");
      wr(3'd0, 8'h77, "R3 tx");
      // R4 divisor bank
      wr(3'd3, 8'h83, "R4");
      wr(3'd0, 8'h34, "R4");
      wr(3'd1, 8'h12, "R4");
      rx_avail = 1;
      rd(3'd0, 8'h34, 0, "R4 dll");
      rd(3'd1, 8'h12, 0, "R4 dlm");
      rx_avail = 0;
      chk("R4 divisor value", divisor, 16'h1234);
      wr(3'd3, 8'h03, "R4");
      rd(3'd1, 8'h05, 0, "R4 ier kept");
      // R6/R7 FIFO control
      wr(3'd3, 8'h80, "R7");
      wr(3'd2, 8'h27, "R7 big with bank");
      wr(3'd3, 8'h03, "R7");
      rd(3'd2, 8'hE1, 0, "R7 iir big");
      wr(3'd2, 8'h01, "R7 bit5 ignored");
      rd(3'd2, 8'hE1, 0, "R7 big held");
      wr(3'd3, 8'h80, "R7");
      wr(3'd2, 8'h01, "R7 clear big");
      wr(3'd3, 8'h03, "R6");
      rd(3'd2, 8'hC1, 0, "R6 fifo flags");
      wr(3'd2, 8'h00, "R6 off");
      rd(3'd2, 8'h01, 0, "R6 fifo off");
      // R5 enhanced bank
      wr(3'd3, 8'hBF, "R5");
      wr(3'd2, 8'hC0, "R5 efr");
      rd(3'd2, 8'hC0, 0, "R5 efr read");
      rd(3'd7, 8'h00, 0, "R5 scratch hidden");
      wr(3'd7, 8'h11, "R5 scratch write ignored");
      wr(3'd3, 8'h03, "R5");
      rd(3'd7, 8'hA5, 0, "R5 scratch restored");
      rd(3'd2, 8'h01, 0, "R5 iir back");
      // R12 writes to status offsets
      wr(3'd5, 8'hFF, "R12");
      wr(3'd6, 8'hFF, "R12");
      rd(3'd5, exp_lsr(), 0, "R12 lsr unchanged");
      rd(3'd6, 8'h00, 0, "R12 msr unchanged");
      // R8/R11 status and priority
      wr(3'd1, 8'h0F, "R11");
      rx_avail = 1;
      pulse_ovr();
      rd(3'd2, 8'h06, 0, "R11 line first");
      rd(3'd5, 8'h63, 0, "R8 lsr overrun");
      rd(3'd5, 8'h61, 0, "R8 overrun cleared");
      rd(3'd2, 8'h04, 0, "R11 rx second");
      rx_avail = 0;
      rd(3'd2, 8'h02, 0, "R11 tx third");
      tx_room = 0; tx_empty = 0;
      rd(3'd5, 8'h00, 0, "R8 lsr busy");
      rd(3'd2, 8'h01, 0, "R11 none");
      // R10 modem status
      set_modem(4'b1010);
      rd(3'd2, 8'h00, 0, "R11 modem last");
      rd(3'd6, 8'hAA, 0, "R10 msr delta");
      rd(3'd6, 8'hA0, 0, "R10 delta cleared");
      rd(3'd2, 8'h01, 0, "R10 modem int gone");
      tx_room = 1; tx_empty = 1;
      repeat (2) @(posedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule